// File: doc/BRIEF.md
# Timing-Recovery PI Loop Filter

This block is the loop compensation stage of a symbol timing-recovery loop. Each time the phase detector presents a new signed phase-error sample, it strobes `err_valid`. The filter first scales the sample by a selectable detector gain. It then updates an integrating accumulator and adds a proportional term. The result is registered as a signed frequency-control word that an oscillator downstream consumes.

An 8-bit control register sets the detector gain, the loop-gain pair, a freeze bit and two fields that are only stored: the clock-range select and the symbol-negate bit. The loop can be frozen either by the register bit or by the `freeze_in` pin. While frozen, the proportional path is zeroed and the integrator stops, so the output settles on the integrator value and holds there. All coefficients are powers of two and are applied as arithmetic shifts. The integrator and the output clamp at the signed limits instead of wrapping.

Top module: `tr_loop_filter`

## Requirements
- R1: While `rst_n` is low and after it is released, the control register reads 8'h00. The accumulator and `freq_word` are zero and `freq_valid` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata`, and `cfg_rdata` returns it from the next cycle. Bits [7:6] are clock range, bit 5 is negate, bits [4:3] are detector gain, bit 2 is freeze and bits [1:0] are loop gain. Without `cfg_we` the register keeps its value.
- R3: The detector gain code multiplies the error sample: 00 by 1, 01 by 2, 10 by 4, and the reserved 11 by 1.
- R4: The loop gain code selects the proportional and integral coefficients as a pair: 00 gives 1 and 1, 01 gives 4 and 32, 10 gives 16 and 256, 11 gives 64 and 4096.
- R5: On a strobe that is not frozen, the accumulator becomes sat(acc + e·Ki) and `freq_word` becomes sat(new acc + e·Kp), where e is the scaled error. `freq_valid` is high in exactly the cycle after each strobe. `freq_word` does not change between strobes.
- R6: On a strobe with the freeze bit or `freeze_in` set, the accumulator keeps its value and `freq_word` becomes the accumulator value, with no proportional contribution.
- R7: Once freeze is cleared, later strobes resume both the proportional term and the integrator updates from the held accumulator value.
- R8: The accumulator and `freq_word` saturate at +2^31-1 and -2^31 for the default 32-bit width and never wrap.
- R9: The clock-range and negate fields have no effect on `freq_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| freeze_in | input | 1 | External loop freeze |
| err_valid | input | 1 | Phase-error update strobe |
| err_in | input | 12 | Signed phase-error sample |
| freq_valid | output | 1 | New frequency word present |
| freq_word | output | 32 | Signed frequency-control word |

## Verification
A constant positive error step is applied under each of the four loop-gain codes. The growth rate separates the integral coefficient, and the offset above the accumulator separates the proportional coefficient. A negative error applied under all four detector codes shows whether scaling, sign handling and the reserved code are right. Freeze is then applied through the register bit and through the pin, followed by a resume, which tells a held integrator apart from a zeroed proportional term. Long runs at the largest positive and negative inputs drive both clamps.

// File: rtl/tr_loop_pkg.sv
package tr_loop_pkg;

  // Control register layout; the field order is the bit order, MSB first.
  typedef struct packed {
    logic [1:0] clk_range;
    logic       negate;
    logic [1:0] det_gain;
    logic       freeze;
    logic [1:0] loop_gain;
  } loop_cfg_t;

  localparam int unsigned SHW = 4;

  // Proportional coefficient as a left shift amount.
  function automatic logic [SHW-1:0] prop_shift(input logic [1:0] code);
    case (code)
      2'd0:    return SHW'(0);
      2'd1:    return SHW'(2);
      2'd2:    return SHW'(4);
      default: return SHW'(6);
    endcase
  endfunction

  // Integral coefficient as a left shift amount.
  function automatic logic [SHW-1:0] integ_shift(input logic [1:0] code);
    case (code)
      2'd0:    return SHW'(0);
      2'd1:    return SHW'(5);
      2'd2:    return SHW'(8);
      default: return SHW'(12);
    endcase
  endfunction

endpackage

// File: rtl/loop_cfg_reg.sv
module loop_cfg_reg
  import tr_loop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic [7:0] wdata,
  output loop_cfg_t cfg
);

  loop_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = loop_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q)); // R2

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == loop_cfg_t'($past(wdata)))); // R2

endmodule

// File: rtl/err_scaler.sv
module err_scaler #(
  parameter int unsigned EW = 12,
  localparam int unsigned SW = EW + 2
) (
  input  logic signed [EW-1:0] err,
  input  logic        [1:0]    code,
  output logic signed [SW-1:0] scaled
);

  logic signed [SW-1:0] ext;

  assign ext = SW'(err);

  always_comb begin
    case (code)
      2'd1:    scaled = ext <<< 1;
      2'd2:    scaled = ext <<< 2;
      default: scaled = ext;      // 00 and reserved 11 both give unity
    endcase
  end

endmodule

// File: rtl/pi_core.sv
module pi_core
  import tr_loop_pkg::*;
#(
  parameter int unsigned SW = 14,
  parameter int unsigned AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic                 frz,
  input  logic signed [SW-1:0] e,
  input  logic [SHW-1:0]       kp_sh,
  input  logic [SHW-1:0]       ki_sh,
  output logic signed [AW-1:0] out,
  output logic                 valid
);

  localparam int unsigned XW = AW + 1;
  localparam logic signed [XW-1:0] MAXE = {2'b00, {(AW-1){1'b1}}};
  localparam logic signed [XW-1:0] MINE = {2'b11, {(AW-1){1'b0}}};

  function automatic logic signed [AW-1:0] clamp(input logic signed [XW-1:0] v);
    if (v > MAXE)      return MAXE[AW-1:0];
    else if (v < MINE) return MINE[AW-1:0];
    else               return v[AW-1:0];
  endfunction

  logic signed [AW-1:0] acc_q, acc_d, out_q, out_d;
  logic                 val_q, val_d;
  logic signed [XW-1:0] e_x, inc_x, prop_x, acc_sum, out_sum;
  logic signed [AW-1:0] acc_n, out_n;

  assign e_x     = XW'(e);
  assign inc_x   = e_x <<< ki_sh;
  assign prop_x  = e_x <<< kp_sh;
  assign acc_sum = XW'(acc_q) + inc_x;
  assign acc_n   = clamp(acc_sum);
  assign out_sum = XW'(acc_n) + prop_x;
  assign out_n   = clamp(out_sum);

  always_comb begin
    acc_d = acc_q;
    out_d = out_q;
    val_d = upd;
    if (upd) begin
      if (frz) begin
        out_d = acc_q;
      end else begin
        acc_d = acc_n;
        out_d = out_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= '0;
      val_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      out_q <= out_d;
      val_q <= val_d;
    end
  end

  assign out   = out_q;
  assign valid = val_q;

  AST_VALID_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> valid); // R5
  AST_VALID_ONLY_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> !valid); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(out_q)); // R5
  AST_FREEZE_ACC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && frz) |=> $stable(acc_q)); // R6
  AST_FREEZE_OUT_IS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && frz) |=> (out_q == acc_q)); // R6
  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !frz && !e[SW-1]) |=> (acc_q >= $past(acc_q))); // R8
  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !frz && e[SW-1]) |=> (acc_q <= $past(acc_q))); // R8

endmodule

// File: rtl/tr_loop_filter.sv
module tr_loop_filter
  import tr_loop_pkg::*;
#(
  parameter int unsigned EW = 12,
  parameter int unsigned AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic                 freeze_in,
  input  logic                 err_valid,
  input  logic signed [EW-1:0] err_in,
  output logic                 freq_valid,
  output logic signed [AW-1:0] freq_word
);

  localparam int unsigned SW = EW + 2;

  loop_cfg_t            cfg;
  logic signed [SW-1:0] err_s;
  logic                 frz_eff;

  loop_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  err_scaler #(.EW(EW)) u_scale (
    .err    (err_in),
    .code   (cfg.det_gain),
    .scaled (err_s)
  );

  assign frz_eff = cfg.freeze | freeze_in;

  pi_core #(.SW(SW), .AW(AW)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (err_valid),
    .frz   (frz_eff),
    .e     (err_s),
    .kp_sh (prop_shift(cfg.loop_gain)),
    .ki_sh (integ_shift(cfg.loop_gain)),
    .out   (freq_word),
    .valid (freq_valid)
  );

  assign cfg_rdata = cfg;

endmodule

// File: tb/tr_loop_filter_test.sv
module tr_loop_filter_test;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_we;
  logic [7:0]         cfg_wdata;
  logic [7:0]         cfg_rdata;
  logic               freeze_in;
  logic               err_valid;
  logic signed [11:0] err_in;
  logic               freq_valid;
  logic signed [31:0] freq_word;

  always #10 clk = ~clk;  // 50 MHz

  tr_loop_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .freeze_in(freeze_in), .err_valid(err_valid),
    .err_in(err_in), .freq_valid(freq_valid), .freq_word(freq_word)
  );

  int total = 0;
  int fails = 0;
  longint exp_q[$];
  string  tag_q[$];

  longint m_acc;
  logic [7:0] m_cfg;
  bit m_pin;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  // Reference model built from R3..R6, R8
  function automatic longint model(input longint err);
    longint g, e, kp, ki;
    case (m_cfg[4:3]) 2'd1: g = 2; 2'd2: g = 4; default: g = 1; endcase
    case (m_cfg[1:0]) 2'd0: begin kp = 1; ki = 1; end
                      2'd1: begin kp = 4; ki = 32; end
                      2'd2: begin kp = 16; ki = 256; end
                      default: begin kp = 64; ki = 4096; end endcase
    e = err * g;
    if (m_cfg[2] || m_pin) return m_acc;
    m_acc = sat(m_acc + e * ki);
    return sat(m_acc + e * kp);
  endfunction

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && freq_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected valid", 1, 0);
      else begin
        longint ev;
        string tg;
        ev = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(longint'(freq_word) == ev, tg, longint'(freq_word), ev);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
    chk(freq_word == 0, "R1 freq", freq_word, 0);
    chk(freq_valid == 1'b0, "R1 valid", freq_valid, 0);
    rst_n = 1'b1;
    m_acc = 0;
    m_cfg = 8'h00;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_cfg = v;
    chk(cfg_rdata == v, "R2 readback", cfg_rdata, v);
  endtask

  task automatic send(input int err, input string tg);
    @(negedge clk);
    err_in = 12'(err);
    err_valid = 1'b1;
    exp_q.push_back(model(longint'(err)));
    tag_q.push_back(tg);
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    longint held;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; freeze_in = 1'b0;
    err_valid = 1'b0; err_in = '0; m_pin = 1'b0;
    do_reset();

    // R4: step response per loop-gain code
    for (int lg = 0; lg < 4; lg++) begin
      do_reset();
      wr_cfg(8'(lg));
      for (int k = 0; k < 4; k++) send(5, "R4 step");
    end

    // R3: detector gain codes including reserved
    for (int dg = 0; dg < 4; dg++) begin
      do_reset();
      wr_cfg(8'((dg << 3) | 1));
      for (int k = 0; k < 3; k++) send(-7, "R3 det gain");
    end

    // R9: stored-only fields
    do_reset();
    wr_cfg(8'hE2);
    for (int k = 0; k < 3; k++) send(9, "R9 inert fields");
    wr_cfg(8'h20);
    send(-3, "R9 inert fields");

    // R5: output holds between strobes
    repeat (4) @(negedge clk);
    held = longint'(freq_word);
    repeat (5) @(negedge clk);
    chk(longint'(freq_word) == held, "R5 hold", freq_word, held);
    chk(freq_valid == 1'b0, "R5 valid idle", freq_valid, 0);

    // R6/R7: freeze via register bit, then resume
    do_reset();
    wr_cfg(8'h01);
    send(20, "R5 update");
    send(20, "R5 update");
    wr_cfg(8'h05);
    send(100, "R6 reg freeze");
    send(-100, "R6 reg freeze");
    wr_cfg(8'h01);
    send(20, "R7 resume");
    send(-3, "R7 resume");

    // R6/R7: freeze via pin
    @(negedge clk); freeze_in = 1'b1; m_pin = 1'b1;
    send(50, "R6 pin freeze");
    send(50, "R6 pin freeze");
    @(negedge clk); freeze_in = 1'b0; m_pin = 1'b0;
    send(50, "R7 pin resume");

    // R8: saturation at both ends
    do_reset();
    wr_cfg(8'h13);
    for (int k = 0; k < 70; k++) send(2047, "R8 pos sat");
    chk(longint'(freq_word) == 64'sd2147483647, "R8 pos limit", freq_word, 64'sd2147483647);
    for (int k = 0; k < 140; k++) send(-2048, "R8 neg sat");
    chk(longint'(freq_word) == -64'sd2147483648, "R8 neg limit", freq_word, -64'sd2147483648);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule